// File: doc/BRIEF.md
# One-Shot Window/Timeout Watchdog

This block supervises software through a single command byte that arrives on a register interface as a one-cycle strobe with eight data bits. The first byte arms the watchdog. The byte also chooses the mode and one of eight periods. Each later byte counts as a service. A service restarts the timer from zero and applies whatever mode and period that byte carries. All time is counted in units of a one-millisecond tick input, so the clock frequency does not affect the timing.

There are two modes. In timeout mode, a service is accepted at any point before the period runs out. In window mode, the first half of the period is closed. A service in the closed half is a fault and fires the reset at once. A service in the second half is accepted.

When the period expires or a window fault occurs, the block drives an active-low reset pulse. The pulse lasts a fixed base hold plus a configurable extra hold. After the pulse the block disarms, and it stays quiet until a new command arms it again.

Top module: `wdt_oneshot`

## Requirements
- R1: While reset is asserted and after it is released, `wdt_rst_n` is high and the watchdog is disarmed.
- R2: Without a command, no number of ticks ever drives `wdt_rst_n` low.
- R3: In the command byte, bit 7 selects the mode (1 = window, 0 = timeout) and bits 2:0 hold a select value s. The period is PERIOD_BASE_MS << s ticks. Bits 6:3 have no effect.
- R4: Once armed with no further command, `wdt_rst_n` goes low in the cycle after the tick that completes the period, and not before.
- R5: A command accepted while armed clears the count to zero, and the period and mode of the new byte apply from then on.
- R6: In timeout mode, a command at any count below the period is accepted as a service.
- R7: In window mode, a command that arrives while the count is below half the period drives `wdt_rst_n` low in the next cycle.
- R8: In window mode, a command that arrives while the count is at or above half the period is accepted as a service.
- R9: `wdt_rst_n` stays low for exactly HOLD_BASE_MS + HOLD_EXTRA_MS ticks and then returns high.
- R10: A command that arrives while `wdt_rst_n` is low has no effect. It neither lengthens the pulse nor arms the watchdog.
- R11: After the pulse ends, the watchdog is disarmed and stays quiet until a new command arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_ms | input | 1 | One-cycle pulse per millisecond, the time base |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte: mode in bit 7, period select in bits 2:0 |
| wdt_rst_n | output | 1 | Active-low reset pulse output |

## Verification
The reset output is the only place where the internal state can be seen. A count that is off, or a period decoded from the wrong bits, shows up as a falling edge one or more ticks away from the expected tick. The bench therefore samples both just before and exactly at the expected expiry tick. A wrong window boundary turns an accepted service into an immediate low output, or turns a fault into no pulse at all; either one is visible in the cycle after the command. A state machine that fails to disarm, or that accepts commands during the pulse, shows up as a pulse of the wrong length or as a stray second pulse during the long quiet stretch that follows.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SEL_W = 3;
  localparam int NSEL  = 1 << SEL_W;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_HOLD  = 2'd2
  } wd_state_e;

  typedef enum logic {
    WD_MODE_TIMEOUT = 1'b0,
    WD_MODE_WINDOW  = 1'b1
  } wd_mode_e;

  typedef struct packed {
    wd_mode_e           mode;
    logic [SEL_W-1:0]   sel;
  } wd_cfg_t;

  // Mode in bit 7, period select in the low bits; the rest is don't-care.
  function automatic wd_cfg_t wd_decode(input logic [7:0] b);
    wd_cfg_t c;
    c.mode = b[7] ? WD_MODE_WINDOW : WD_MODE_TIMEOUT;
    c.sel  = b[SEL_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/wdt_period_lut.sv
module wdt_period_lut
  import wdt_pkg::*;
#(
  parameter int PERIOD_BASE = 10,
  parameter int CW          = 11
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CW-1:0]    period,
  output logic [CW-1:0]    half
);

  logic [CW-1:0] tab [NSEL];

  // Period doubles with each select step.
  for (genvar i = 0; i < NSEL; i++) begin : g_tab
    assign tab[i] = CW'(PERIOD_BASE << i);
  end

  assign period = tab[sel];
  assign half   = period >> 1;

endmodule

// File: rtl/wdt_period_timer.sv
module wdt_period_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] half,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          closed
);

  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt    = cnt_q;
  assign last   = (cnt_q == period - CW'(1));
  assign closed = (cnt_q < half);

endmodule

// File: rtl/wdt_hold_timer.sv
module wdt_hold_timer #(
  parameter int HOLD_LEN = 15,
  parameter int HW       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic inc,
  output logic done
);

  logic [HW-1:0] hcnt_d;
  logic [HW-1:0] hcnt_q;
  logic          hcnt_en;

  always_comb begin
    hcnt_en = start | inc;
    hcnt_d  = hcnt_q;
    if (start) begin
      hcnt_d = '0;
    end else if (inc) begin
      hcnt_d = hcnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
    end else if (hcnt_en) begin
      hcnt_q <= hcnt_d;
    end
  end

  assign done = inc && (hcnt_q == HW'(HOLD_LEN - 1));

endmodule

// File: rtl/wdt_oneshot.sv
module wdt_oneshot
  import wdt_pkg::*;
#(
  parameter int PERIOD_BASE_MS = 10,
  parameter int HOLD_BASE_MS   = 10,
  parameter int HOLD_EXTRA_MS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  output logic       wdt_rst_n
);

  localparam int MAX_PERIOD = PERIOD_BASE_MS << (NSEL - 1);
  localparam int CW         = $clog2(MAX_PERIOD + 1);
  localparam int HOLD_LEN   = HOLD_BASE_MS + HOLD_EXTRA_MS;
  localparam int HW         = $clog2(HOLD_LEN + 1);

  logic          rst_core_n;
  wd_state_e     state_q, state_d;
  wd_cfg_t       cfg_q, cfg_d;
  logic          cfg_en;
  logic          out_q, out_d;
  logic [CW-1:0] period, half, cnt;
  logic          last, closed;
  logic          load, fire, hold_done, cnt_inc, hold_inc;

  wdt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  wdt_period_lut #(
    .PERIOD_BASE (PERIOD_BASE_MS),
    .CW          (CW)
  ) u_lut (
    .sel    (cfg_q.sel),
    .period (period),
    .half   (half)
  );

  wdt_period_timer #(
    .CW (CW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr    (load),
    .inc    (cnt_inc),
    .period (period),
    .half   (half),
    .cnt    (cnt),
    .last   (last),
    .closed (closed)
  );

  wdt_hold_timer #(
    .HOLD_LEN (HOLD_LEN),
    .HW       (HW)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (fire),
    .inc   (hold_inc),
    .done  (hold_done)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    fire    = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        if (cmd_valid) begin
          load    = 1'b1;
          state_d = WD_ARMED;
        end
      end
      WD_ARMED: begin
        if (cmd_valid) begin
          if (cfg_q.mode == WD_MODE_WINDOW && closed) begin
            fire    = 1'b1;
            state_d = WD_HOLD;
          end else begin
            load = 1'b1;
          end
        end else if (tick_ms && last) begin
          fire    = 1'b1;
          state_d = WD_HOLD;
        end
      end
      WD_HOLD: begin
        if (hold_done) begin
          state_d = WD_IDLE;
        end
      end
      default: state_d = WD_IDLE;
    endcase
  end

  assign cnt_inc  = tick_ms && (state_q == WD_ARMED) && !load && !fire;
  assign hold_inc = tick_ms && (state_q == WD_HOLD);
  assign cfg_en   = load;
  assign cfg_d    = wd_decode(cmd_data);
  assign out_d    = (state_d != WD_HOLD);

  // Registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= WD_IDLE;
      out_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cfg_q <= '{mode: WD_MODE_TIMEOUT, sel: '0};
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign wdt_rst_n = out_q;

endmodule

// File: rtl/wdt_oneshot_chk.sv
module wdt_oneshot_chk
  import wdt_pkg::*;
#(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_ms,
  input logic          cmd_valid,
  input logic          wdt_rst_n,
  input wd_state_e     state_q,
  input wd_mode_e      mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] period,
  input logic [CW-1:0] half
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == WD_IDLE |-> wdt_rst_n);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == WD_ARMED |-> cnt < period);

  assert_closed_service_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_ARMED && mode == WD_MODE_WINDOW && cnt < half && cmd_valid)
    |=> (!wdt_rst_n && state_q == WD_HOLD));

  assert_service_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_ARMED && cmd_valid && !(mode == WD_MODE_WINDOW && cnt < half))
    |=> (state_q == WD_ARMED && cnt == '0 && wdt_rst_n));

  assert_hold_ignores_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_HOLD && !tick_ms) |=> (state_q == WD_HOLD && !wdt_rst_n));

  assert_release_disarms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_n) |-> state_q == WD_IDLE);

endmodule

bind wdt_oneshot wdt_oneshot_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .tick_ms   (tick_ms),
  .cmd_valid (cmd_valid),
  .wdt_rst_n (wdt_rst_n),
  .state_q   (state_q),
  .mode      (cfg_q.mode),
  .cnt       (cnt),
  .period    (period),
  .half      (half)
);

// File: tb/wdt_oneshot_tb.sv
module wdt_oneshot_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PBASE      = 4;
  localparam int HBASE      = 10;
  localparam int HEXTRA     = 3;
  localparam int HLEN       = HBASE + HEXTRA;
  localparam int NVEC       = 7;

  // Command byte and expected period in ticks (R3: PBASE << bits 2:0)
  localparam logic [7:0] VEC_CMD [NVEC] = '{8'h00, 8'h01, 8'h7A, 8'hC3, 8'h05, 8'h86, 8'hFF};
  localparam int         VEC_PER [NVEC] = '{4, 8, 16, 32, 128, 256, 512};

  logic       clk;
  logic       rst_n;
  logic       tick_ms;
  logic       cmd_valid;
  logic [7:0] cmd_data;
  logic       wdt_rst_n;

  int n_checks;
  int n_fails;

  wdt_oneshot #(
    .PERIOD_BASE_MS (PBASE),
    .HOLD_BASE_MS   (HBASE),
    .HOLD_EXTRA_MS  (HEXTRA)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_ms   (tick_ms),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .wdt_rst_n (wdt_rst_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: wdt_rst_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    tick_ms   = 1'b0;
    cmd_valid = 1'b0;
    cmd_data  = 8'h00;
    rst_n     = 1'b0;
    #(CLK_PERIOD * 2);
    check("R1 in reset", wdt_rst_n, 1'b1);
    do_reset();
    check("R1 after reset", wdt_rst_n, 1'b1);

    // R2: ticks alone never fire
    ticks(600);
    check("R2 no command", wdt_rst_n, 1'b1);

    // Vector table: period decode (R3) and expiry timing (R4)
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      send(VEC_CMD[v]);
      ticks(VEC_PER[v] - 1);
      check("R3 R4 before expiry", wdt_rst_n, 1'b1);
      ticks(1);
      check("R3 R4 at expiry", wdt_rst_n, 1'b0);
    end

    // R6: timeout service just before expiry, then R9 pulse length, R11 one-shot
    do_reset();
    send(8'h00);
    ticks(3);
    send(8'h00);
    ticks(3);
    check("R6 serviced late", wdt_rst_n, 1'b1);
    ticks(1);
    check("R6 expiry after service", wdt_rst_n, 1'b0);
    ticks(HLEN - 1);
    check("R9 still low", wdt_rst_n, 1'b0);
    ticks(1);
    check("R9 released", wdt_rst_n, 1'b1);
    ticks(600);
    check("R11 stays disarmed", wdt_rst_n, 1'b1);

    // R5: new settings take effect (sel 0 then sel 1 => 8 ticks)
    do_reset();
    send(8'h00);
    ticks(2);
    send(8'h01);
    ticks(7);
    check("R5 new period before", wdt_rst_n, 1'b1);
    ticks(1);
    check("R5 new period at", wdt_rst_n, 1'b0);

    // R7: window closed half, count 1 of 4
    do_reset();
    send(8'h80);
    ticks(1);
    send(8'h80);
    check("R7 closed service fires", wdt_rst_n, 1'b0);

    // R7 boundary: count 3 of 8 is still closed
    do_reset();
    send(8'h81);
    ticks(3);
    send(8'h81);
    check("R7 boundary closed", wdt_rst_n, 1'b0);

    // R8: count 4 of 8 is open; the new byte switches to period 4
    do_reset();
    send(8'h81);
    ticks(4);
    send(8'h80);
    check("R8 open service accepted", wdt_rst_n, 1'b1);
    ticks(3);
    check("R8 restart before", wdt_rst_n, 1'b1);
    ticks(1);
    check("R8 restart at", wdt_rst_n, 1'b0);

    // R10: commands during the pulse are ignored
    ticks(2);
    send(8'h07);
    ticks(HLEN - 3);
    send(8'h00);
    check("R10 still low", wdt_rst_n, 1'b0);
    ticks(1);
    check("R10 length unchanged", wdt_rst_n, 1'b1);
    ticks(520);
    check("R10 no arming", wdt_rst_n, 1'b1);

    // R11: re-arming after the pulse works again
    send(8'h00);
    ticks(4);
    check("R11 re-armed fires", wdt_rst_n, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule